// File: doc/BRIEF.md
# Serial Control Port with Latched Alarm Interrupts

This block is the host-side control port of a line-interface device. A controller writes one configuration byte per chip-select frame over a three-wire serial link: an active-low select, a serial clock and a data input. Bits arrive least significant first. The byte takes effect in the configuration register only when the frame carries exactly eight clock edges. During the same frame the block shifts an 8-bit status word out on a serial data output. That output is left floating (high impedance) whenever the select is inactive.

Two alarm sources, loss of signal and a driver fault, arrive as single-cycle pulses in the system-clock domain. Each one is latched into a pending flag. Any pending flag pulls the active-low interrupt output low. A flag is cleared only by committing a byte whose matching clear bit is 1. Reading status never clears it, and an alarm pulse in the same cycle as its clear keeps the flag set. Two encodings of the upper three bits are reserved for a test mode. A byte carrying either encoding raises a test-mode flag and changes nothing else. All serial inputs pass through two-flop synchronisers, and every edge is detected in the system-clock domain.

Top module: `ctl_serial_port`

## Requirements
- R1: After reset the configuration output is 0x00, test_mode_o is 0, los_o is 1 (loss-of-signal pending) and the driver-fault flag is clear, so int_n_o is 0.
- R2: The byte is shifted in LSB first, with data sampled on rising serial-clock edges while cs_n_i is low. When cs_n_i rises after exactly 8 rising edges, the byte is committed to cfg_o.
- R3: A frame with fewer or more than 8 rising serial-clock edges is discarded. It leaves cfg_o, test_mode_o and the alarm flags unchanged.
- R4: A pulse on los_evt_i sets the loss-of-signal flag (los_o = 1), and a pulse on dpm_evt_i sets the driver-fault flag. Each flag stays set after its source pulse ends, and int_n_o is 0 while either flag is set.
- R5: A committed byte with bit 0 = 1 clears the loss-of-signal flag, and one with bit 1 = 1 clears the driver-fault flag. The two clears act independently, and int_n_o returns to 1 only when both flags are clear.
- R6: An alarm pulse in the same cycle as its own clear wins, so the flag stays set.
- R7: Readback frames do not clear pending flags. This covers committed bytes whose clear bits are 0 and discarded frames of any length.
- R8: A committed byte whose bits [7:5] are 101 or 111 sets test_mode_o to 1 and leaves cfg_o and both alarm flags unchanged. The next committed byte with any other code in those bits sets test_mode_o to 0 and is applied normally.
- R9: During a frame, sdo_o presents the status word {cfg[7:2], driver-fault flag, loss-of-signal flag} captured when the select falls. The word is sent LSB first and advances after each falling serial-clock edge. sdo_o is high impedance while the select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Serial chip select, active low, asynchronous to clk |
| sclk_i | input | 1 | Serial clock, idle low, asynchronous to clk |
| sdi_i | input | 1 | Serial data in, LSB first |
| los_evt_i | input | 1 | Loss-of-signal event pulse |
| dpm_evt_i | input | 1 | Driver-fault event pulse |
| sdo_o | output | 1 | Serial status out, high impedance when idle |
| int_n_o | output | 1 | Interrupt, active low, set while any alarm flag is pending |
| los_o | output | 1 | Loss-of-signal pending flag |
| cfg_o | output | 8 | Committed configuration byte |
| test_mode_o | output | 1 | Reserved test-mode code was committed |

## Verification
A wrong bit counter or a bad shift direction shows up at the ports three or four system clocks after the select rises. It appears as a wrong or missing cfg_o update, or as a short or long frame being accepted. A flag that was set or cleared in error appears on int_n_o and los_o at once. It appears again at the start of the next frame, because the readback word carries both flags. A stale status shifter shows up within one serial-clock period as a wrong bit on sdo_o, compared bit for bit against the word the bench expects.

// File: rtl/ctl_port_pkg.sv
// Shared constants and helpers for the serial control port.
// Assumes an 8-bit control word; field positions are set here.
package ctl_port_pkg;
    localparam int BYTE_W      = 8;
    localparam int CLR_LOS_POS = 0;
    localparam int CLR_DPM_POS = 1;
    localparam int CODE_HI     = 7;
    localparam int CODE_LO     = 5;
    localparam int N_ALARM     = 2;

    // Returns 1 for the reserved test encodings of the upper bits.
    function automatic logic is_test_code(input logic [2:0] code);
        return (code == 3'b101) || (code == 3'b111);
    endfunction
endpackage

// File: rtl/cps_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; per-bit reset value is RST_VAL.
module cps_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // One register stage of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= (s == 0) ? d : stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cps_frame.sv
// Frame engine: detects serial clock and select edges on synchronised
// inputs, shifts in the control byte LSB first, shifts out the status
// word, and pulses commit when a frame of exactly W edges closes.
// Assumes sclk idles low and select edges do not coincide with sclk edges.
module cps_frame #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n_s,
    input  logic         sclk_s,
    input  logic         sdi_s,
    input  logic [W-1:0] status_i,
    output logic         commit_o,
    output logic [W-1:0] byte_o,
    output logic         sdo_bit_o,
    output logic         active_o
);
    localparam int CNT_MAX = W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             sclk_q, cs_n_q;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     sh_in, sh_out;
    logic             sclk_rise, sclk_fall, cs_fall, cs_rise;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign cs_fall   = ~cs_n_s & cs_n_q;
    assign cs_rise   = cs_n_s & ~cs_n_q;

    // Previous-cycle copies used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_n_q <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            cs_n_q <= cs_n_s;
        end
    end

    // Shift, count and commit logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            sh_in    <= '0;
            sh_out   <= '0;
            commit_o <= 1'b0;
        end else begin
            commit_o <= 1'b0;
            if (cs_fall) begin
                cnt    <= '0;
                sh_out <= status_i;
            end else if (!cs_n_s) begin
                if (sclk_rise) begin
                    sh_in <= {sdi_s, sh_in[W-1:1]};
                    if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
                end
                if (sclk_fall) sh_out <= {1'b0, sh_out[W-1:1]};
            end
            if (cs_rise && cnt == CNT_W'(W)) commit_o <= 1'b1;
        end
    end

    assign byte_o    = sh_in;
    assign sdo_bit_o = sh_out[0];
    assign active_o  = ~cs_n_s;

    // R3: the edge counter saturates and never passes its limit.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(CNT_MAX));
    // R2: a commit only follows a frame that held exactly W edges.
    a_r2_commit_len: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (cnt == CNT_W'(W)) && cs_n_s);
endmodule

// File: rtl/cps_alarm.sv
// Sticky alarm flag: set by an event pulse, cleared by a clear pulse;
// the event wins when both arrive in the same cycle.
// Assumes event and clear are single-cycle system-clock pulses.
module cps_alarm #(
    parameter logic RST_PEND = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic pend_o
);
    // Flag update with event priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_o <= RST_PEND;
        else if (evt_i) pend_o <= 1'b1;
        else if (clr_i) pend_o <= 1'b0;
    end

    // R4: an event always leaves the flag set.
    a_r4_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> pend_o);
    // R6: a clear in the event cycle does not drop the flag.
    a_r6_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && clr_i) |=> pend_o);
    // R5: a lone clear drops the flag.
    a_r5_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i) |=> !pend_o);
    // R7: without a clear, a set flag stays set.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);
endmodule

// File: rtl/ctl_serial_port.sv
// Serial control port top: synchronises the serial link, holds the
// configuration byte, latches two alarm flags into an active-low
// interrupt and drives a tri-state status output.
// Assumes alarm events are system-clock pulses; serial pins are async.
module ctl_serial_port
    import ctl_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              los_evt_i,
    input  logic              dpm_evt_i,
    output logic              sdo_o,
    output logic              int_n_o,
    output logic              los_o,
    output logic [BYTE_W-1:0] cfg_o,
    output logic              test_mode_o
);
    logic [2:0]         sync_q;
    logic               commit, sdo_bit, active, test_hit;
    logic [BYTE_W-1:0]  rx_byte, status;
    logic [N_ALARM-1:0] evt, clr, pend;

    localparam logic [N_ALARM-1:0] PEND_RST = 2'b01;

    cps_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n_i, sclk_i, sdi_i}), .q(sync_q)
    );

    assign status = {cfg_o[BYTE_W-1:N_ALARM], pend};

    cps_frame #(.W(BYTE_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(sync_q[2]), .sclk_s(sync_q[1]), .sdi_s(sync_q[0]),
        .status_i(status), .commit_o(commit), .byte_o(rx_byte),
        .sdo_bit_o(sdo_bit), .active_o(active)
    );

    assign test_hit = is_test_code(rx_byte[CODE_HI:CODE_LO]);

    // Configuration register and test-mode flag update on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o       <= '0;
            test_mode_o <= 1'b0;
        end else if (commit) begin
            test_mode_o <= test_hit;
            if (!test_hit) cfg_o <= rx_byte;
        end
    end

    assign evt = {dpm_evt_i, los_evt_i};
    assign clr = {commit & ~test_hit & rx_byte[CLR_DPM_POS],
                  commit & ~test_hit & rx_byte[CLR_LOS_POS]};

    genvar a;
    generate
        for (a = 0; a < N_ALARM; a++) begin : g_alarm
            cps_alarm #(.RST_PEND(PEND_RST[a])) u_alarm (
                .clk(clk), .rst_n(rst_n),
                .evt_i(evt[a]), .clr_i(clr[a]), .pend_o(pend[a])
            );
        end
    endgenerate

    assign int_n_o = ~|pend;
    assign los_o   = pend[0];
    assign sdo_o   = active ? sdo_bit : 1'bz;

    // R8: a reserved code leaves the configuration untouched.
    a_r8_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && test_hit) |=> $stable(cfg_o) && test_mode_o);
    // R3: cfg_o changes only in the cycle after a commit.
    a_r3_cfg_only_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg_o));
    // R4: the interrupt is asserted whenever an alarm flag is pending.
    a_r4_int_low: assert property (@(posedge clk) disable iff (!rst_n)
        (los_o || pend[1]) |-> !int_n_o);
endmodule

// File: tb/sim_ctl_serial_port.sv
// Scoreboard bench: the transfer task pushes expected readback words,
// a monitor pops and compares them against captured sdo bits.
module sim_ctl_serial_port;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic       los_evt = 1'b0, dpm_evt = 1'b0;
    wire        sdo;
    logic       int_n, los;
    logic [7:0] cfg;
    logic       tm;

    int n_chk = 0, n_err = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] rx_byte;
    event       rx_ev;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    ctl_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .los_evt_i(los_evt), .dpm_evt_i(dpm_evt), .sdo_o(sdo),
        .int_n_o(int_n), .los_o(los), .cfg_o(cfg), .test_mode_o(tm)
    );

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares each received readback word with the queue head.
    initial begin
        forever begin
            @(rx_ev);
            chk(rx_byte === exp_q[0], tag_q[0], rx_byte, exp_q[0]);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    // Driver: one frame of n edges; 8-edge frames push an expected word.
    task automatic xfer(input logic [7:0] d, input int n, input logic [7:0] exp_rd, input string tag);
        logic [7:0] got = 8'h00;
        if (n == 8) begin
            exp_q.push_back(exp_rd);
            tag_q.push_back(tag);
        end
        cs_n = 1'b0;
        #80;
        for (int i = 0; i < n; i++) begin
            sdi = d[i % 8];
            #80;
            if (i < 8) got[i] = sdo;
            sclk = 1'b1;
            #80;
            sclk = 1'b0;
        end
        #80;
        cs_n = 1'b1;
        #300;
        if (n == 8) begin
            rx_byte = got;
            ->rx_ev;
            #10;
        end
    endtask

    task automatic pulse(input bit which_dpm);
        @(posedge clk); #2;
        if (which_dpm) dpm_evt = 1'b1; else los_evt = 1'b1;
        @(posedge clk); #2;
        dpm_evt = 1'b0; los_evt = 1'b0;
        #50;
    endtask

    initial begin
        #2;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        #100;
        // R1 reset state
        chk(cfg === 8'h00, "R1 cfg", cfg, 8'h00);
        chk(tm === 1'b0, "R1 test_mode", {7'b0, tm}, 8'h00);
        chk(los === 1'b1, "R1 los", {7'b0, los}, 8'h01);
        chk(int_n === 1'b0, "R1 int_n", {7'b0, int_n}, 8'h00);
        chk(sdo === 1'bz, "R9 sdo idle z", {7'b0, sdo}, 8'h00);

        // R2/R5: clear LOS, readback shows LOS pending
        xfer(8'h01, 8, 8'h01, "R9 readback after reset");
        chk(cfg === 8'h01, "R2 cfg 01", cfg, 8'h01);
        chk(los === 1'b0, "R5 los cleared", {7'b0, los}, 8'h00);
        chk(int_n === 1'b1, "R5 int_n released", {7'b0, int_n}, 8'h01);

        xfer(8'h5C, 8, 8'h00, "R9 readback clean");
        chk(cfg === 8'h5C, "R2 cfg 5C", cfg, 8'h5C);

        // R4: driver-fault pulse latches
        pulse(1'b1);
        chk(int_n === 1'b0, "R4 int_n on dpm", {7'b0, int_n}, 8'h00);
        #200;
        chk(int_n === 1'b0, "R4 int_n sticky", {7'b0, int_n}, 8'h00);
        chk(los === 1'b0, "R4 los untouched", {7'b0, los}, 8'h00);

        // R7: readback with clear bits 0
        xfer(8'h5C, 8, 8'h5E, "R9 readback dpm");
        chk(int_n === 1'b0, "R7 read keeps int", {7'b0, int_n}, 8'h00);

        // R3: short and long frames are discarded
        xfer(8'h02, 5, 8'h00, "");
        chk(cfg === 8'h5C, "R3 short frame cfg", cfg, 8'h5C);
        chk(int_n === 1'b0, "R3 short frame int", {7'b0, int_n}, 8'h00);
        xfer(8'hFF, 9, 8'h00, "");
        chk(cfg === 8'h5C, "R3 long frame cfg", cfg, 8'h5C);
        chk(int_n === 1'b0, "R7 long frame int", {7'b0, int_n}, 8'h00);

        // R5: clear driver fault
        xfer(8'h5E, 8, 8'h5E, "R9 readback before dpm clear");
        chk(int_n === 1'b1, "R5 dpm cleared", {7'b0, int_n}, 8'h01);
        chk(cfg === 8'h5E, "R2 cfg 5E", cfg, 8'h5E);

        // R5 independence: clearing DPM leaves LOS
        pulse(1'b0);
        chk(los === 1'b1, "R4 los set", {7'b0, los}, 8'h01);
        xfer(8'h02, 8, 8'h5D, "R9 readback los");
        chk(los === 1'b1, "R5 los kept on dpm clear", {7'b0, los}, 8'h01);
        chk(cfg === 8'h02, "R2 cfg 02", cfg, 8'h02);

        // R8: reserved codes 101 and 111
        xfer(8'hB1, 8, 8'h01, "R9 readback before test");
        chk(tm === 1'b1, "R8 test_mode 101", {7'b0, tm}, 8'h01);
        chk(cfg === 8'h02, "R8 cfg held 101", cfg, 8'h02);
        chk(los === 1'b1, "R8 no clear in test", {7'b0, los}, 8'h01);
        xfer(8'hE0, 8, 8'h01, "R9 readback in test");
        chk(tm === 1'b1, "R8 test_mode 111", {7'b0, tm}, 8'h01);
        chk(cfg === 8'h02, "R8 cfg held 111", cfg, 8'h02);
        xfer(8'hC1, 8, 8'h01, "R9 readback leaving test");
        chk(tm === 1'b0, "R8 test_mode exit", {7'b0, tm}, 8'h00);
        chk(cfg === 8'hC1, "R8 cfg after exit", cfg, 8'hC1);
        chk(los === 1'b0, "R5 los cleared after exit", {7'b0, los}, 8'h00);

        // R6: event held across the clear commit keeps the flag
        #2 los_evt = 1'b1;
        xfer(8'h01, 8, 8'hC1, "R9 readback with event");
        #2 los_evt = 1'b0;
        #50;
        chk(los === 1'b1, "R6 event beats clear", {7'b0, los}, 8'h01);
        xfer(8'h01, 8, 8'h01, "R9 readback after R6");
        chk(los === 1'b0, "R5 final clear", {7'b0, los}, 8'h00);
        chk(sdo === 1'bz, "R9 sdo z after frame", {7'b0, sdo}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        #1500000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule